// File: doc/BRIEF.md
# Clock Source Mode Controller

This block sits beside a clock generator. It turns the generator's control fields into one operating mode and drives the generator's enables from that mode. The inputs are a two-bit source-select field, a reference-select bit, a low-power bit, a debug-active flag and an external reference divider setting. The outputs are a mode code, an enable for the internal reference oscillator, an enable for the external reference, an enable for the FLL, the FLL reference selection and the select for the output clock mux. All of these outputs are registered on the system clock.

The block also contains a digital lock monitor. It counts rising edges of the FLL output that arrive between consecutive rising edges of the divided reference. It reports lock when several windows in a row come close to the 1024-to-1 target ratio. It also flags an external divider setting that places a known nominal external frequency outside the FLL's input window. The FLL and reference inputs are expected to be already synchronous to the system clock.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: With source-select 00 and reference-select 0, the mode code becomes 1 (engaged, external). The external reference enable is 1, the FLL reference selection is external (1), the output select is 0 (FLL) and the FLL enable is 1.
- R2: With source-select 00 and reference-select 1, the mode code becomes 0 (engaged, internal). The output select is 0 and the FLL reference selection is 0.
- R3: With source-select 01, reference-select 1, and either debug active or the low-power bit 0, the mode code becomes 2 (bypassed, internal). The output select is 1 (internal reference) and the FLL enable stays 1.
- R4: With source-select 01, reference-select 1, debug inactive and the low-power bit 1, the mode code becomes 3 (bypassed, internal, low power). The output select is 1 and the FLL enable is 0.
- R5: The internal reference enable is 1 in modes 0, 2 and 3 and 0 in mode 1. The external reference enable is 1 only in mode 1.
- R6: The divider error flag is 1 exactly when the mode is 1 and the nominal external frequency, divided by the divider, falls outside the range 31.25 kHz to 39.0625 kHz inclusive. The divider is 2^e with the range bit at 0, or 32*2^e with the range bit at 1, where e is the 3-bit divider exponent.
- R7: Any other control combination leaves the mode and all enables unchanged and sets the invalid-config flag. The flag stays set until a valid combination is presented, and that combination clears it.
- R8: The lock flag rises after 4 consecutive complete reference windows whose FLL edge count lies within 1022 to 1026. The first reference edge after a restart only opens a window.
- R9: The lock flag falls on the first complete window whose count lies outside 1022 to 1026.
- R10: Each mode change clears the lock flag and restarts the monitor. The lock flag is 0 whenever the FLL enable is 0.
- R11: All outputs change one system clock after the inputs that cause the change. A synchronous active-low reset sets mode 0, the internal reference enable to 1, the FLL enable to 1, and every other output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 2 | Output source select field |
| ref_int | input | 1 | Reference select, 1 = internal |
| low_pwr | input | 1 | Low-power request |
| dbg_active | input | 1 | Debug session active |
| div_exp | input | 3 | External divider exponent |
| div_rng_hi | input | 1 | External divider range, 1 adds factor 32 |
| fll_clk_in | input | 1 | FLL output, sampled |
| ref_clk_in | input | 1 | Divided FLL reference, sampled |
| mode_o | output | 2 | Current mode code |
| irc_en_o | output | 1 | Internal reference enable |
| ext_en_o | output | 1 | External reference enable |
| fll_en_o | output | 1 | FLL enable |
| fll_ref_ext_o | output | 1 | FLL reference selection, 1 = external |
| out_sel_ref_o | output | 1 | Output mux select, 1 = internal reference |
| div_err_o | output | 1 | Divider out of window in external mode |
| cfg_invalid_o | output | 1 | Sticky invalid control combination |
| fll_lock_o | output | 1 | FLL lock indication |

## Verification
A wrong decoded mode shows up on the mode code and the enables one system clock after the control fields change. A mode that was wrongly kept shows up the same way. An error in the monitor's window counter or consecutive-window counter cannot be seen until the next reference edge, which can be about 2000 system clocks later. For that reason, the bench moves the reference period across the edges of the tolerance band and compares the lock output on every clock. It also checks that a mode change or a disabled FLL drops lock in the same cycle as the new mode.

// File: rtl/clkgen_mode_pkg.sv
package clkgen_mode_pkg;

    typedef enum logic [1:0] {
        MODE_ENG_INT    = 2'd0,
        MODE_ENG_EXT    = 2'd1,
        MODE_BYP_INT    = 2'd2,
        MODE_BYP_INT_LP = 2'd3
    } clk_mode_e;

    typedef struct packed {
        clk_mode_e mode;
        logic      irc_en;
        logic      ext_en;
        logic      fll_en;
        logic      fll_ref_ext;
        logic      out_sel_ref;
        logic      div_err;
        logic      cfg_invalid;
    } ctrl_state_t;

    localparam ctrl_state_t CTRL_RESET = '{
        mode:        MODE_ENG_INT,
        irc_en:      1'b1,
        ext_en:      1'b0,
        fll_en:      1'b1,
        fll_ref_ext: 1'b0,
        out_sel_ref: 1'b0,
        div_err:     1'b0,
        cfg_invalid: 1'b0
    };

endpackage

// File: rtl/clk_mode_decode.sv
module clk_mode_decode
    import clkgen_mode_pkg::*;
(
    input  logic [1:0] src_sel,
    input  logic       ref_int,
    input  logic       low_pwr,
    input  logic       dbg_active,
    output logic       valid_o,
    output clk_mode_e  mode_o
);

    always_comb begin
        valid_o = 1'b0;
        mode_o  = MODE_ENG_INT;
        unique case (src_sel)
            2'b00: begin
                valid_o = 1'b1;
                mode_o  = ref_int ? MODE_ENG_INT : MODE_ENG_EXT;
            end
            2'b01: begin
                if (ref_int) begin
                    valid_o = 1'b1;
                    mode_o  = (low_pwr && !dbg_active) ? MODE_BYP_INT_LP : MODE_BYP_INT;
                end
            end
            default: begin
                valid_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ext_ref_range_check.sv
module ext_ref_range_check #(
    parameter longint unsigned EXT_FREQ_HZ = 64'd32768,
    parameter int unsigned     DIV_EXP_W   = 3,
    parameter int unsigned     HI_RANGE_SH = 5
) (
    input  logic [DIV_EXP_W-1:0] div_exp,
    input  logic                 div_rng_hi,
    output logic                 in_range_o
);

    localparam int unsigned NDIV = 1 << DIV_EXP_W;
    // window bounds scaled to integers: 31250*2 and 39062.5*16
    localparam longint unsigned LO_X2  = 64'd62500;
    localparam longint unsigned HI_X16 = 64'd625000;

    logic [2*NDIV-1:0] ok_tab;

    for (genvar g = 0; g < 2 * NDIV; g++) begin : g_tab
        localparam int unsigned     SHIFT = (g % NDIV) + ((g >= NDIV) ? HI_RANGE_SH : 0);
        localparam longint unsigned DIV   = 64'd1 << SHIFT;
        assign ok_tab[g] = (EXT_FREQ_HZ * 64'd2 >= LO_X2 * DIV) &&
                           (EXT_FREQ_HZ * 64'd16 <= HI_X16 * DIV);
    end

    always_comb begin
        in_range_o = ok_tab[{div_rng_hi, div_exp}];
    end

endmodule

// File: rtl/clk_lock_monitor.sv
module clk_lock_monitor #(
    parameter int unsigned TARGET = 1024,
    parameter int unsigned TOL    = 2,
    parameter int unsigned NEED   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic fll_in,
    input  logic ref_in,
    output logic lock_o
);

    localparam int unsigned CNT_MAX = TARGET + TOL + 1;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam int unsigned GOOD_W  = $clog2(NEED + 1);
    localparam logic [CNT_W-1:0]  WIN_LO    = CNT_W'(TARGET - TOL);
    localparam logic [CNT_W-1:0]  WIN_HI    = CNT_W'(TARGET + TOL);
    localparam logic [CNT_W-1:0]  CNT_SAT   = CNT_W'(CNT_MAX);
    localparam logic [GOOD_W-1:0] GOOD_FULL = GOOD_W'(NEED);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              armed;
        logic [GOOD_W-1:0] good;
        logic              lock;
        logic              fll_prev;
        logic              ref_prev;
    } mon_t;

    mon_t mon_d, mon_q;
    logic fll_edge, ref_edge, in_win;
    logic [GOOD_W-1:0] good_inc;

    always_comb begin
        fll_edge = fll_in && !mon_q.fll_prev;
        ref_edge = ref_in && !mon_q.ref_prev;
        in_win   = (mon_q.cnt >= WIN_LO) && (mon_q.cnt <= WIN_HI);
        good_inc = (mon_q.good == GOOD_FULL) ? GOOD_FULL : mon_q.good + GOOD_W'(1);

        mon_d          = mon_q;
        mon_d.fll_prev = fll_in;
        mon_d.ref_prev = ref_in;

        if (restart) begin
            mon_d.cnt   = '0;
            mon_d.armed = 1'b0;
            mon_d.good  = '0;
            mon_d.lock  = 1'b0;
        end else if (ref_edge) begin
            if (mon_q.armed) begin
                if (in_win) begin
                    mon_d.good = good_inc;
                    mon_d.lock = (good_inc == GOOD_FULL);
                end else begin
                    mon_d.good = '0;
                    mon_d.lock = 1'b0;
                end
            end
            mon_d.armed = 1'b1;
            mon_d.cnt   = fll_edge ? CNT_W'(1) : '0;
        end else if (fll_edge && mon_q.armed && (mon_q.cnt != CNT_SAT)) begin
            mon_d.cnt = mon_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_q <= '0;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign lock_o = mon_q.lock;

    AST_LOCK_RISES_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mon_q.lock) |-> ($past(ref_in) && !$past(mon_q.ref_prev))); // R8

    AST_RESTART_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !lock_o); // R10

endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl
    import clkgen_mode_pkg::*;
#(
    parameter longint unsigned EXT_FREQ_HZ = 64'd32768,
    parameter int unsigned     DIV_EXP_W   = 3,
    parameter int unsigned     LOCK_TARGET = 1024,
    parameter int unsigned     LOCK_TOL    = 2,
    parameter int unsigned     LOCK_NEED   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           src_sel,
    input  logic                 ref_int,
    input  logic                 low_pwr,
    input  logic                 dbg_active,
    input  logic [DIV_EXP_W-1:0] div_exp,
    input  logic                 div_rng_hi,
    input  logic                 fll_clk_in,
    input  logic                 ref_clk_in,
    output logic [1:0]           mode_o,
    output logic                 irc_en_o,
    output logic                 ext_en_o,
    output logic                 fll_en_o,
    output logic                 fll_ref_ext_o,
    output logic                 out_sel_ref_o,
    output logic                 div_err_o,
    output logic                 cfg_invalid_o,
    output logic                 fll_lock_o
);

    ctrl_state_t st_d, st_q;
    logic        dec_valid;
    clk_mode_e   dec_mode;
    logic        div_in_range;
    logic        mon_restart;

    clk_mode_decode u_decode (
        .src_sel    (src_sel),
        .ref_int    (ref_int),
        .low_pwr    (low_pwr),
        .dbg_active (dbg_active),
        .valid_o    (dec_valid),
        .mode_o     (dec_mode)
    );

    ext_ref_range_check #(
        .EXT_FREQ_HZ (EXT_FREQ_HZ),
        .DIV_EXP_W   (DIV_EXP_W)
    ) u_range (
        .div_exp    (div_exp),
        .div_rng_hi (div_rng_hi),
        .in_range_o (div_in_range)
    );

    always_comb begin
        st_d             = st_q;
        st_d.cfg_invalid = !dec_valid;
        if (dec_valid) begin
            st_d.mode = dec_mode;
        end
        st_d.irc_en      = (st_d.mode != MODE_ENG_EXT);
        st_d.ext_en      = (st_d.mode == MODE_ENG_EXT);
        st_d.fll_en      = (st_d.mode != MODE_BYP_INT_LP);
        st_d.fll_ref_ext = (st_d.mode == MODE_ENG_EXT);
        st_d.out_sel_ref = (st_d.mode == MODE_BYP_INT) || (st_d.mode == MODE_BYP_INT_LP);
        st_d.div_err     = (st_d.mode == MODE_ENG_EXT) && !div_in_range;
        mon_restart      = (st_d.mode != st_q.mode) || !st_d.fll_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= CTRL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    clk_lock_monitor #(
        .TARGET (LOCK_TARGET),
        .TOL    (LOCK_TOL),
        .NEED   (LOCK_NEED)
    ) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (mon_restart),
        .fll_in  (fll_clk_in),
        .ref_in  (ref_clk_in),
        .lock_o  (fll_lock_o)
    );

    assign mode_o        = st_q.mode;
    assign irc_en_o      = st_q.irc_en;
    assign ext_en_o      = st_q.ext_en;
    assign fll_en_o      = st_q.fll_en;
    assign fll_ref_ext_o = st_q.fll_ref_ext;
    assign out_sel_ref_o = st_q.out_sel_ref;
    assign div_err_o     = st_q.div_err;
    assign cfg_invalid_o = st_q.cfg_invalid;

    AST_EXT_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(src_sel == 2'b00 && !ref_int)) |-> (mode_o == 2'd1 && ext_en_o)); // R1

    AST_LP_FLL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(src_sel == 2'b01 && ref_int && low_pwr && !dbg_active)) |-> !fll_en_o); // R4

    AST_INVALID_HOLDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_invalid_o |-> (mode_o == $past(mode_o))); // R7

    AST_MODE_CHANGE_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != $past(mode_o)) |-> !fll_lock_o); // R10

    AST_NO_LOCK_FLL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !fll_en_o |-> !fll_lock_o); // R10

endmodule

// File: tb/clkgen_mode_ctrl_tb_top.sv
module clkgen_mode_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic       ref_int = 1'b1;
    logic       low_pwr = 1'b0;
    logic       dbg_active = 1'b0;
    logic [2:0] div_exp = 3'd0;
    logic       div_rng_hi = 1'b0;
    logic       fll_clk_in = 1'b0;
    logic       ref_clk_in = 1'b0;
    logic [1:0] mode_o;
    logic       irc_en_o, ext_en_o, fll_en_o, fll_ref_ext_o, out_sel_ref_o;
    logic       div_err_o, cfg_invalid_o, fll_lock_o;

    always #2 clk = ~clk;

    clkgen_mode_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ref_int(ref_int),
        .low_pwr(low_pwr), .dbg_active(dbg_active), .div_exp(div_exp),
        .div_rng_hi(div_rng_hi), .fll_clk_in(fll_clk_in), .ref_clk_in(ref_clk_in),
        .mode_o(mode_o), .irc_en_o(irc_en_o), .ext_en_o(ext_en_o),
        .fll_en_o(fll_en_o), .fll_ref_ext_o(fll_ref_ext_o),
        .out_sel_ref_o(out_sel_ref_o), .div_err_o(div_err_o),
        .cfg_invalid_o(cfg_invalid_o), .fll_lock_o(fll_lock_o)
    );

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;

    // behavioural reference model state
    int m_mode, m_irc, m_ext, m_fll, m_refx, m_sel, m_derr, m_inv;
    int m_lock, m_cnt, m_armed, m_good, m_pf, m_pr;

    // stimulus generator state
    int ref_period = 1024;
    int edge_cnt = 0;

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic bit div_ok(input int e, input int hi);
        real div, f;
        div = (hi != 0) ? 32.0 * (2.0 ** e) : (2.0 ** e);
        f = 32768.0 / div;
        return (f >= 31250.0) && (f <= 39062.5);
    endfunction

    always @(posedge clk) begin
        int nm, valid, fe, re, restart;
        started = 1;
        if (!rst_n) begin
            m_mode = 0; m_irc = 1; m_ext = 0; m_fll = 1; m_refx = 0; m_sel = 0;
            m_derr = 0; m_inv = 0; m_lock = 0; m_cnt = 0; m_armed = 0; m_good = 0;
            m_pf = 0; m_pr = 0;
        end else begin
            valid = 1; nm = m_mode;
            if (src_sel == 2'b00) nm = ref_int ? 0 : 1;
            else if (src_sel == 2'b01 && ref_int) nm = (low_pwr && !dbg_active) ? 3 : 2;
            else valid = 0;
            restart = (nm != m_mode) || (nm == 3);
            m_mode = nm;
            m_inv  = !valid;
            m_irc  = (nm != 1);
            m_ext  = (nm == 1);
            m_fll  = (nm != 3);
            m_refx = (nm == 1);
            m_sel  = (nm >= 2);
            m_derr = (nm == 1) && !div_ok(div_exp, div_rng_hi);
            fe = fll_clk_in && !m_pf;
            re = ref_clk_in && !m_pr;
            m_pf = fll_clk_in; m_pr = ref_clk_in;
            if (restart) begin
                m_cnt = 0; m_armed = 0; m_good = 0; m_lock = 0;
            end else if (re) begin
                if (m_armed) begin
                    if (m_cnt >= 1022 && m_cnt <= 1026) begin
                        if (m_good < 4) m_good++;
                        m_lock = (m_good >= 4);
                    end else begin
                        m_good = 0; m_lock = 0;
                    end
                end
                m_armed = 1;
                m_cnt = fe;
            end else if (fe && m_armed && m_cnt < 1027) begin
                m_cnt++;
            end
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            chk("R1/R2/R3/R4/R7 mode", mode_o, m_mode);
            chk("R5 irc_en", irc_en_o, m_irc);
            chk("R5 ext_en", ext_en_o, m_ext);
            chk("R3/R4 fll_en", fll_en_o, m_fll);
            chk("R1 fll_ref_ext", fll_ref_ext_o, m_refx);
            chk("R3 out_sel", out_sel_ref_o, m_sel);
            chk("R6 div_err", div_err_o, m_derr);
            chk("R7 cfg_invalid", cfg_invalid_o, m_inv);
            chk("R8/R9/R10 lock", fll_lock_o, m_lock);
        end
        fll_clk_in <= ~fll_clk_in;
        if (!fll_clk_in) begin
            edge_cnt++;
            if (edge_cnt >= ref_period) begin
                edge_cnt = 0;
                ref_clk_in <= 1'b1;
            end else begin
                ref_clk_in <= 1'b0;
            end
        end else begin
            ref_clk_in <= 1'b0;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ctrl(input logic [1:0] s, input logic ri, input logic lp, input logic dbg);
        @(negedge clk);
        src_sel = s; ref_int = ri; low_pwr = lp; dbg_active = dbg;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        wait_cyc(4);
        // R11 reset values
        chk("R11 reset mode", mode_o, 0);
        chk("R11 reset irc_en", irc_en_o, 1);
        chk("R11 reset fll_en", fll_en_o, 1);
        chk("R11 reset lock", fll_lock_o, 0);
        @(negedge clk); rst_n = 1'b1;
        // R8 lock in engaged internal mode
        wait_cyc(12000);
        chk("R8 lock after good windows", fll_lock_o, 1);
        ref_period = 1027;
        wait_cyc(4200);
        chk("R9 lock lost on long window", fll_lock_o, 0);
        ref_period = 1022;
        wait_cyc(12000);
        chk("R8 lock at low tolerance edge", fll_lock_o, 1);
        ref_period = 1026;
        wait_cyc(5000);
        chk("R8 lock kept at high tolerance edge", fll_lock_o, 1);
        // R1 switch to external, R10 unlock
        set_ctrl(2'b00, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R1 external mode", mode_o, 1);
        chk("R10 lock cleared on mode change", fll_lock_o, 0);
        @(negedge clk); div_exp = 3'd1;
        wait_cyc(2);
        chk("R6 divider error flagged", div_err_o, 1);
        div_exp = 3'd0; div_rng_hi = 1'b1;
        wait_cyc(2);
        chk("R6 high range error", div_err_o, 1);
        div_rng_hi = 1'b0;
        ref_period = 1024;
        wait_cyc(12000);
        chk("R6 divider ok", div_err_o, 0);
        chk("R8 lock in external mode", fll_lock_o, 1);
        // R7 invalid combination
        set_ctrl(2'b10, 1'b0, 1'b0, 1'b0);
        wait_cyc(3);
        chk("R7 invalid keeps mode", mode_o, 1);
        chk("R7 invalid flag", cfg_invalid_o, 1);
        set_ctrl(2'b01, 1'b0, 1'b0, 1'b0);
        wait_cyc(3);
        chk("R7 invalid flag sticky", cfg_invalid_o, 1);
        // R3 bypassed internal via debug override
        set_ctrl(2'b01, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        chk("R3 bypass with debug", mode_o, 2);
        chk("R7 invalid flag cleared", cfg_invalid_o, 0);
        chk("R3 output from internal ref", out_sel_ref_o, 1);
        wait_cyc(12000);
        chk("R3 FLL locked while bypassed", fll_lock_o, 1);
        // R4 low power
        set_ctrl(2'b01, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        chk("R4 low power mode", mode_o, 3);
        chk("R4 fll off", fll_en_o, 0);
        chk("R10 lock off with fll off", fll_lock_o, 0);
        wait_cyc(6000);
        chk("R10 lock stays off", fll_lock_o, 0);
        set_ctrl(2'b01, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        chk("R3 bypass with low power clear", mode_o, 2);
        // R2 back to engaged internal
        set_ctrl(2'b00, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        chk("R2 engaged internal", mode_o, 0);
        chk("R5 irc enabled", irc_en_o, 1);
        wait_cyc(20);
        finish_run();
    end

endmodule